// File: doc/BRIEF.md
# Ingress tag source check table

This block is a small exact-match stage placed after header parsing. It is used on a switch whose core links carry a 32-bit route tag. For every packet it takes the ingress port number and a bit that says whether a route tag was parsed. It then returns one of three action codes: pass the packet, strip the tag and record it in metadata, or fault the packet to the CPU. Removing the header from the byte stream and the CPU path are handled by other blocks.

Software fills the table through a write port. Each rule holds an enable bit, a key (ingress port plus tag-valid bit) and exactly one action. A second write port marks which ingress ports face the core. The tag check applies only on those ports. Every other port gets pass. Lookups are pipelined: a request in one cycle gives a registered result in the next cycle. When the action is strip, the tag value is latched into a metadata register together with a tagged flag.

Top module: `tag_src_check`

## Requirements
- R1: After reset, res_valid_o, res_strip_o and meta_tagged_o are 0, res_action_o is 0 (pass), meta_tag_o is 0, every rule is disabled and no port is marked core-facing.
- R2: res_valid_o is high in the cycle after a cycle with lk_valid_i high, and low otherwise. When res_valid_o is low, res_action_o is 0 and res_strip_o is 0.
- R3: A lookup whose port and tag-valid bit both equal the key of an enabled rule, on a core-facing port, returns that rule's action code. The codes are 0 = pass, 1 = strip, 2 = fault to CPU.
- R4: A lookup that matches no enabled rule returns pass (0).
- R5: A lookup on a port not marked core-facing returns pass, even if a rule matches it.
- R6: When several enabled rules match, the rule with the lowest index decides the action.
- R7: res_strip_o is high exactly when the result is strip. On such a result, meta_tag_o holds the lk_tag_i of that request and meta_tagged_o is 1.
- R8: A lookup whose result is not strip clears meta_tagged_o and leaves meta_tag_o unchanged. Cycles with no lookup leave both unchanged.
- R9: A rule or port write affects lookups issued from the cycle after the write. A lookup issued in the same cycle as the write sees the old contents.
- R10: A rule that holds the unused action code 3 returns pass when it matches.
- R11: Writing a rule with its enable bit at 0 stops it from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rule_we_i | input | 1 | Rule write strobe |
| rule_idx_i | input | IDX_W | Rule index to write |
| rule_en_i | input | 1 | Enable bit of the written rule |
| rule_port_i | input | PORT_W | Key port of the written rule |
| rule_tv_i | input | 1 | Key tag-valid bit of the written rule |
| rule_act_i | input | 2 | Action code of the written rule |
| core_we_i | input | 1 | Core-facing attribute write strobe |
| core_port_i | input | PORT_W | Port whose attribute is written |
| core_val_i | input | 1 | 1 marks the port as core-facing |
| lk_valid_i | input | 1 | Lookup request |
| lk_port_i | input | PORT_W | Ingress port of the lookup |
| lk_tv_i | input | 1 | Route tag parsed for this packet |
| lk_tag_i | input | TAG_W | Parsed route tag value |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| res_action_o | output | 2 | Action code |
| res_strip_o | output | 1 | Strip enable |
| meta_tag_o | output | TAG_W | Latched tag metadata |
| meta_tagged_o | output | 1 | Last result stripped a tag |

## Verification
The bound checker checks on every cycle the one-cycle result timing, the idle encoding, the tie between strip and the metadata capture, that the latched tag holds on non-strip results, that code 3 never appears, and that misses and non-core ports give pass. Some behaviours can only be shown by the bench scenarios. These are the choice among overlapping rules, same-cycle write-versus-lookup ordering, disabling a rule, and the exact action returned for each key. The bench shows them by running a behavioural table model and comparing it against the outputs on every clock.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned ACT_W = 2;
  localparam logic [ACT_W-1:0] ACT_PASS  = 2'd0;
  localparam logic [ACT_W-1:0] ACT_STRIP = 2'd1;
  localparam logic [ACT_W-1:0] ACT_FAULT = 2'd2;

  function automatic logic [ACT_W-1:0] act_legal(input logic [ACT_W-1:0] a);
    return (a == ACT_STRIP || a == ACT_FAULT) ? a : ACT_PASS;
  endfunction
endpackage

// File: rtl/tsc_rule_bank.sv
module tsc_rule_bank #(
  parameter int unsigned N_RULES = 64,
  parameter int unsigned PORT_W  = 6,
  localparam int unsigned IDX_W  = $clog2(N_RULES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic                          en_i,
  input  logic [PORT_W-1:0]             port_i,
  input  logic                          tv_i,
  input  logic [tsc_pkg::ACT_W-1:0]     act_i,
  input  logic [PORT_W-1:0]             lk_port_i,
  input  logic                          lk_tv_i,
  output logic [N_RULES-1:0]            hit_o,
  output logic [N_RULES-1:0][tsc_pkg::ACT_W-1:0] act_o
);
  for (genvar g = 0; g < N_RULES; g++) begin : g_rule
    logic              en_q;
    logic              tv_q;
    logic [PORT_W-1:0] port_q;
    logic [tsc_pkg::ACT_W-1:0] act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        tv_q   <= 1'b0;
        port_q <= '0;
        act_q  <= tsc_pkg::ACT_PASS;
      end else if (we_i && idx_i == IDX_W'(g)) begin
        en_q   <= en_i;
        tv_q   <= tv_i;
        port_q <= port_i;
        act_q  <= act_i;
      end
    end

    assign hit_o[g] = en_q && (tv_q == lk_tv_i) && (port_q == lk_port_i);
    assign act_o[g] = act_q;
  end
endmodule

// File: rtl/tsc_hit_pick.sv
module tsc_hit_pick #(
  parameter int unsigned N_RULES = 64
) (
  input  logic [N_RULES-1:0]                     hit_i,
  input  logic [N_RULES-1:0][tsc_pkg::ACT_W-1:0] act_i,
  output logic                                   any_o,
  output logic [tsc_pkg::ACT_W-1:0]              act_o
);
  // lowest index wins
  always_comb begin
    any_o = 1'b0;
    act_o = tsc_pkg::ACT_PASS;
    for (int i = N_RULES - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        act_o = act_i[i];
      end
    end
  end
endmodule

// File: rtl/tsc_port_attr.sv
module tsc_port_attr #(
  parameter int unsigned PORT_W = 6,
  localparam int unsigned N_PORTS = 1 << PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              val_i,
  input  logic [PORT_W-1:0] lk_port_i,
  output logic              core_o
);
  logic [N_PORTS-1:0] core_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   core_q <= '0;
    else if (we_i) core_q[port_i] <= val_i;
  end

  assign core_o = core_q[lk_port_i];
endmodule

// File: rtl/tag_src_check.sv
module tag_src_check #(
  parameter int unsigned N_RULES = 64,
  parameter int unsigned PORT_W  = 6,
  parameter int unsigned TAG_W   = 32,
  localparam int unsigned IDX_W  = $clog2(N_RULES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rule_we_i,
  input  logic [IDX_W-1:0]          rule_idx_i,
  input  logic                      rule_en_i,
  input  logic [PORT_W-1:0]         rule_port_i,
  input  logic                      rule_tv_i,
  input  logic [1:0]                rule_act_i,
  input  logic                      core_we_i,
  input  logic [PORT_W-1:0]         core_port_i,
  input  logic                      core_val_i,
  input  logic                      lk_valid_i,
  input  logic [PORT_W-1:0]         lk_port_i,
  input  logic                      lk_tv_i,
  input  logic [TAG_W-1:0]          lk_tag_i,
  output logic                      res_valid_o,
  output logic [1:0]                res_action_o,
  output logic                      res_strip_o,
  output logic [TAG_W-1:0]          meta_tag_o,
  output logic                      meta_tagged_o
);
  import tsc_pkg::*;

  logic [N_RULES-1:0]            hit;
  logic [N_RULES-1:0][ACT_W-1:0] rule_act;
  logic                          hit_any;
  logic [ACT_W-1:0]              hit_act;
  logic                          core_bit;
  logic [ACT_W-1:0]              act_d;

  tsc_rule_bank #(.N_RULES(N_RULES), .PORT_W(PORT_W)) bank_i (
    .clk_i, .rst_ni,
    .we_i(rule_we_i), .idx_i(rule_idx_i), .en_i(rule_en_i),
    .port_i(rule_port_i), .tv_i(rule_tv_i), .act_i(rule_act_i),
    .lk_port_i, .lk_tv_i,
    .hit_o(hit), .act_o(rule_act)
  );

  tsc_hit_pick #(.N_RULES(N_RULES)) pick_i (
    .hit_i(hit), .act_i(rule_act), .any_o(hit_any), .act_o(hit_act)
  );

  tsc_port_attr #(.PORT_W(PORT_W)) attr_i (
    .clk_i, .rst_ni,
    .we_i(core_we_i), .port_i(core_port_i), .val_i(core_val_i),
    .lk_port_i, .core_o(core_bit)
  );

  assign act_d = (hit_any && core_bit) ? act_legal(hit_act) : ACT_PASS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o   <= 1'b0;
      res_action_o  <= ACT_PASS;
      res_strip_o   <= 1'b0;
      meta_tag_o    <= '0;
      meta_tagged_o <= 1'b0;
    end else begin
      res_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        res_action_o  <= act_d;
        res_strip_o   <= (act_d == ACT_STRIP);
        meta_tagged_o <= (act_d == ACT_STRIP);
        if (act_d == ACT_STRIP) meta_tag_o <= lk_tag_i;
      end else begin
        res_action_o <= ACT_PASS;
        res_strip_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tag_src_check_chk.sv
module tag_src_check_chk #(
  parameter int unsigned PORT_W = 6,
  parameter int unsigned TAG_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [TAG_W-1:0]  lk_tag_i,
  input logic              hit_any,
  input logic              core_bit,
  input logic              res_valid_o,
  input logic [1:0]        res_action_o,
  input logic              res_strip_o,
  input logic [TAG_W-1:0]  meta_tag_o,
  input logic              meta_tagged_o
);
  AST_RES_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> res_valid_o); // R2
  AST_RES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> (!res_valid_o && res_action_o == 2'd0 && !res_strip_o)); // R2
  AST_MISS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !hit_any) |=> res_action_o == 2'd0); // R4
  AST_EDGE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !core_bit) |=> res_action_o == 2'd0); // R5
  AST_STRIP_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i ##1 res_strip_o) |-> (meta_tagged_o && meta_tag_o == $past(lk_tag_i) && res_action_o == 2'd1)); // R7
  AST_TAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_strip_o |-> $stable(meta_tag_o)); // R8
  AST_NO_CODE3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_action_o != 2'd3); // R10
endmodule

bind tag_src_check tag_src_check_chk #(.PORT_W(PORT_W), .TAG_W(TAG_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_tag_i(lk_tag_i),
  .hit_any(hit_any), .core_bit(core_bit),
  .res_valid_o(res_valid_o), .res_action_o(res_action_o), .res_strip_o(res_strip_o),
  .meta_tag_o(meta_tag_o), .meta_tagged_o(meta_tagged_o)
);

// File: tb/tag_src_check_tb_top.sv
`timescale 1ns/1ps
module tag_src_check_tb_top;
  localparam int N = 64;
  localparam int PW = 6;
  localparam int TW = 32;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic          rule_we = 0, rule_en = 0, rule_tv = 0;
  logic [5:0]    rule_idx = 0;
  logic [PW-1:0] rule_port = 0;
  logic [1:0]    rule_act = 0;
  logic          core_we = 0, core_val = 0;
  logic [PW-1:0] core_port = 0;
  logic          lk_valid = 0, lk_tv = 0;
  logic [PW-1:0] lk_port = 0;
  logic [TW-1:0] lk_tag = 0;
  logic          res_valid, res_strip, meta_tagged;
  logic [1:0]    res_action;
  logic [TW-1:0] meta_tag;

  tag_src_check #(.N_RULES(N), .PORT_W(PW), .TAG_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rule_we_i(rule_we), .rule_idx_i(rule_idx), .rule_en_i(rule_en),
    .rule_port_i(rule_port), .rule_tv_i(rule_tv), .rule_act_i(rule_act),
    .core_we_i(core_we), .core_port_i(core_port), .core_val_i(core_val),
    .lk_valid_i(lk_valid), .lk_port_i(lk_port), .lk_tv_i(lk_tv), .lk_tag_i(lk_tag),
    .res_valid_o(res_valid), .res_action_o(res_action), .res_strip_o(res_strip),
    .meta_tag_o(meta_tag), .meta_tagged_o(meta_tagged)
  );

  int n_run = 0, n_fail = 0;

  // behavioural table model
  bit       m_en[N];
  bit       m_tv[N];
  int       m_port[N];
  int       m_act[N];
  bit       m_core[64];
  bit       e_valid, e_strip, e_tagged;
  int       e_act;
  logic [TW-1:0] e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_en[i]) begin m_en[i] = 0; m_tv[i] = 0; m_port[i] = 0; m_act[i] = 0; end
      foreach (m_core[i]) m_core[i] = 0;
      e_valid = 0; e_strip = 0; e_tagged = 0; e_act = 0; e_tag = 0;
    end else begin
      e_valid = lk_valid;
      if (lk_valid) begin
        int a;
        a = 0;
        for (int i = 0; i < N; i++)
          if (m_en[i] && m_tv[i] == lk_tv && m_port[i] == int'(lk_port)) begin
            a = m_act[i];
            break;
          end
        if (a == 3 || !m_core[lk_port]) a = 0;
        e_act = a;
        e_strip = (a == 1);
        e_tagged = (a == 1);
        if (a == 1) e_tag = lk_tag;
      end else begin
        e_act = 0;
        e_strip = 0;
      end
      if (rule_we) begin
        m_en[rule_idx] = rule_en; m_tv[rule_idx] = rule_tv;
        m_port[rule_idx] = int'(rule_port); m_act[rule_idx] = int'(rule_act);
      end
      if (core_we) m_core[core_port] = core_val;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R2 res_valid", res_valid, e_valid);
    chk("R3 res_action", res_action, e_act);
    chk("R7 res_strip", res_strip, e_strip);
    chk("R7/R8 meta_tag", meta_tag, e_tag);
    chk("R8 meta_tagged", meta_tagged, e_tagged);
  end

  task automatic wr_rule(input int idx, input bit en, input int port, input bit tv, input int act);
    @(negedge clk);
    rule_we = 1; rule_idx = 6'(idx); rule_en = en; rule_port = PW'(port); rule_tv = tv; rule_act = 2'(act);
    @(negedge clk);
    rule_we = 0;
  endtask

  task automatic set_core(input int port, input bit v);
    @(negedge clk);
    core_we = 1; core_port = PW'(port); core_val = v;
    @(negedge clk);
    core_we = 0;
  endtask

  // issue lookup, check action one cycle later
  task automatic look(input int port, input bit tv, input logic [TW-1:0] tag,
                      input int exp_act, input string req);
    @(negedge clk);
    lk_valid = 1; lk_port = PW'(port); lk_tv = tv; lk_tag = tag;
    rule_we = 0;
    @(negedge clk);
    lk_valid = 0;
    chk(req, res_action, exp_act);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", res_valid, 0);
    chk("R1 action", res_action, 0);
    chk("R1 tag", meta_tag, 0);
    chk("R1 tagged", meta_tagged, 0);
    rst_n = 1;
    look(3, 1, 32'h1, 0, "R1 empty table pass");

    set_core(3, 1); set_core(5, 1); set_core(9, 1); set_core(63, 1);
    wr_rule(0, 1, 3, 1, 1);
    look(3, 1, 32'hA1B2C3D4, 1, "R3 strip hit");
    chk("R7 strip", res_strip, 1);
    chk("R7 tag", meta_tag, 32'hA1B2C3D4);
    chk("R7 tagged", meta_tagged, 1);
    look(3, 0, 32'h55, 0, "R4 miss on tv");
    look(4, 1, 32'h55, 0, "R4 miss on port");
    wr_rule(1, 1, 3, 0, 2);
    look(3, 0, 32'h77, 2, "R3 fault hit");
    chk("R8 tag held", meta_tag, 32'hA1B2C3D4);
    chk("R8 tagged cleared", meta_tagged, 0);
    wr_rule(2, 1, 7, 1, 2);
    look(7, 1, 32'h9, 0, "R5 non-core pass");
    wr_rule(4, 1, 5, 1, 2);
    wr_rule(3, 1, 5, 1, 1);
    look(5, 1, 32'hBEEF, 1, "R6 lowest index");
    // R9: write and lookup in same cycle
    @(negedge clk);
    rule_we = 1; rule_idx = 6; rule_en = 1; rule_port = 9; rule_tv = 1; rule_act = 2;
    lk_valid = 1; lk_port = 9; lk_tv = 1; lk_tag = 32'h3;
    @(negedge clk);
    rule_we = 0; lk_valid = 0;
    chk("R9 same-cycle old", res_action, 0);
    look(9, 1, 32'h3, 2, "R9 next-cycle new");
    wr_rule(7, 1, 5, 0, 3);
    look(5, 0, 32'h4, 0, "R10 code3 pass");
    wr_rule(0, 0, 3, 1, 1);
    look(3, 1, 32'h8, 0, "R11 disabled");
    wr_rule(N - 1, 1, 63, 1, 1);
    look(63, 1, 32'hFFFF0001, 1, "R3 last rule max port");
    set_core(63, 0);
    look(63, 1, 32'h2, 0, "R5 core cleared");
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule